// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Port

This block is a full-duplex asynchronous serial port driven by a small register bus. On the send side, software places a byte in a holding register. The byte moves by itself into a shift register as soon as the line shifter is idle, so the next byte can be written while the current frame is still going out. On the receive side, a shift register assembles the incoming frame. When the frame completes, the byte is copied into a read-only data register. Software can therefore collect one byte while the next one is arriving.

Frames carry 7 or 8 data bits, an optional even or odd parity bit, and one or two stop bits. For 8-bit frames the data can go most-significant-bit first. Each bit lasts 16 divided ticks. The divided tick comes from an external tick pulse, slowed by a power-of-two prescaler selected in the format register. Status flags can only be cleared by software, and three interrupt lines are derived from those flags.

Top module: `uart_dbuf`

## Requirements
- R1: After reset the status register reads 8'h01: bit0 (transmit holding empty) is 1, and bit1 (receive full), bit2 (overrun), bit3 (parity error) and bit4 (framing error) are 0. The txd line is high and all interrupt lines are low.
- R2: Address 3 is the transmit holding register. A pending byte is one whose empty flag has been cleared. It moves into the shifter one cycle after three conditions hold together: the flag is 0, sending is enabled, and the shifter is idle. The empty flag then returns to 1. A byte written while a frame is still shifting keeps the flag at 0 until that frame ends.
- R3: A transmitted frame is a low start bit, the data bits, the parity bit when format bit1 is set (bit2 = 1 selects odd parity, 0 selects even), and then one stop bit, or two when format bit3 is set. Every bit lasts 16 x 2^k ticks, where k is format bits [5:4].
- R4: Control bit4 selects most-significant-bit-first order for both directions. When format bit0 selects 7-bit frames, the order is least-significant-bit first regardless of control bit4, and only bits [6:0] are sent or received.
- R5: A received frame completes at the middle of its first stop bit. The byte is then copied to address 4 and the receive-full flag is set, provided the flag was clear or is being cleared in that same cycle.
- R6: When a frame completes while the receive-full flag is set and not being cleared in that cycle, the overrun flag is set and address 4 keeps its old value.
- R7: A frame whose parity bit disagrees with the selected sense sets status bit3. A frame whose stop bit is sampled low sets status bit4.
- R8: A status flag is cleared only by writing 0 to its bit at address 2, and only after a read of address 2 that returned that bit as 1. Writing 1 has no effect, and a write of 0 with no such prior read has no effect.
- R9: Writes to address 4 are ignored.
- R10: With control bit0 at 0, txd is high from the next cycle onward, even in the middle of a frame. With control bit1 at 0, frames on rxd are ignored.
- R11: irq_tx equals the transmit-empty flag ANDed with control bit2. irq_rx equals the receive-full flag ANDed with control bit3. irq_err equals the OR of the three error flags ANDed with control bit3.
- R12: When a frame completes in the same cycle as a software clear of the receive-full flag, the flag stays 1, the new byte is stored, and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle tick pulse before the prescaler |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address: 0 format, 1 control, 2 status, 3 transmit, 4 receive |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, idle high |
| irq_tx | output | 1 | Transmit-empty interrupt |
| irq_rx | output | 1 | Receive-full interrupt |
| irq_err | output | 1 | Receive error interrupt |

## Verification
Two functions can land in the same cycle: completion of a received frame, and a software clear of the receive-full flag that has already been armed by a status read. The bench provokes this by sending a second frame while the flag is still set, and by issuing the clear write at each cycle offset across a window that spans the predicted completion edge. Every offset must yield exactly one of two outcomes:
- clear early or together: flag 1, new byte, no overrun;
- clear late: overrun, old byte, flag 0.

The early outcome must hold at the lower offsets and the late outcome at the higher ones, with a single crossover. The same-cycle case therefore has to fall on the early side.

// File: rtl/uart_dbuf_pkg.sv
package uart_dbuf_pkg;

  localparam logic [2:0] A_FMT  = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_TXB  = 3'd3;
  localparam logic [2:0] A_RXB  = 3'd4;

  localparam int F_TXE = 0;
  localparam int F_RXF = 1;
  localparam int F_OVR = 2;
  localparam int F_PAR = 3;
  localparam int F_FRM = 4;
  localparam int NFLAG = 5;

  typedef enum logic [2:0] {
    L_IDLE, L_START, L_DATA, L_PAR, L_STOP1, L_STOP2
  } line_st_e;

  typedef struct packed {
    logic len7;
    logic par_en;
    logic par_odd;
    logic stop2;
    logic msb;
  } fmt_t;

  function automatic logic [2:0] last_idx(input logic len7);
    return len7 ? 3'd6 : 3'd7;
  endfunction

  function automatic logic pick_bit(input logic [7:0] b, input logic [2:0] idx,
                                    input logic msb);
    return msb ? b[3'd7 - idx] : b[idx];
  endfunction

  function automatic logic [7:0] take_bit(input logic [7:0] sh, input logic v,
                                          input logic msb);
    return msb ? {sh[6:0], v} : {v, sh[7:1]};
  endfunction

  function automatic logic [7:0] finish_rx(input logic [7:0] sh, input logic len7);
    return len7 ? {1'b0, sh[7:1]} : sh;
  endfunction

  function automatic logic par_of(input logic [7:0] d, input logic len7,
                                  input logic odd);
    return (^(len7 ? {1'b0, d[6:0]} : d)) ^ odd;
  endfunction

endpackage

// File: rtl/uart_tick_div.sv
module uart_tick_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic [DIV_W-1:0] sel,
  output logic             tick_out
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) lim[i] = (i < int'(sel));
  end

  assign tick_out = tick_in && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (tick_out) cnt_q <= '0;
    else if (tick_in)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_dbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tk,
  input  logic       load,
  input  logic [7:0] ld_data,
  input  fmt_t       fmt,
  output logic       txd,
  output logic       busy
);
  line_st_e   st;
  logic [3:0] cnt;
  logic [2:0] idx;
  logic [7:0] sh;
  fmt_t       cfg;
  logic       line;

  assign txd  = line;
  assign busy = (st != L_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= L_IDLE; cnt <= '0; idx <= '0; sh <= '0; cfg <= '0; line <= 1'b1;
    end else if (!en) begin
      st <= L_IDLE; cnt <= '0; line <= 1'b1;
    end else if (st == L_IDLE) begin
      if (load) begin
        sh <= ld_data; cfg <= fmt; st <= L_START; line <= 1'b0;
        cnt <= '0; idx <= '0;
      end
    end else if (tk) begin
      if (cnt != 4'd15) begin
        cnt <= cnt + 4'd1;
      end else begin
        cnt <= '0;
        unique case (st)
          L_START: begin
            st <= L_DATA; line <= pick_bit(sh, 3'd0, cfg.msb);
          end
          L_DATA: begin
            if (idx == last_idx(cfg.len7)) begin
              if (cfg.par_en) begin
                st <= L_PAR; line <= par_of(sh, cfg.len7, cfg.par_odd);
              end else begin
                st <= L_STOP1; line <= 1'b1;
              end
            end else begin
              idx  <= idx + 3'd1;
              line <= pick_bit(sh, idx + 3'd1, cfg.msb);
            end
          end
          L_PAR:   begin st <= L_STOP1; line <= 1'b1; end
          L_STOP1: st <= cfg.stop2 ? L_STOP2 : L_IDLE;
          default: st <= L_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
  import uart_dbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tk,
  input  logic       rxd,
  input  fmt_t       fmt,
  output logic       done,
  output logic [7:0] data,
  output logic       perr,
  output logic       ferr
);
  line_st_e   st;
  logic [3:0] cnt;
  logic [2:0] idx;
  logic [7:0] sh;
  logic       s1, s2, prev, pbit;
  logic       fall, mid, half;

  assign fall = prev && !s2;
  assign mid  = tk && (cnt == 4'd15);
  assign half = tk && (cnt == 4'd7);
  assign done = en && (st == L_STOP1) && mid;
  assign data = finish_rx(sh, fmt.len7);
  assign perr = fmt.par_en && (pbit != par_of(data, fmt.len7, fmt.par_odd));
  assign ferr = !s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
    end else begin
      s1 <= rxd; s2 <= s1; prev <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= L_IDLE; cnt <= '0; idx <= '0; sh <= '0; pbit <= 1'b0;
    end else if (!en) begin
      st <= L_IDLE; cnt <= '0;
    end else begin
      unique case (st)
        L_IDLE: if (fall) begin st <= L_START; cnt <= '0; end
        L_START: begin
          if (half) begin
            cnt <= '0; idx <= '0;
            st  <= s2 ? L_IDLE : L_DATA;
          end else if (tk) cnt <= cnt + 4'd1;
        end
        L_DATA: begin
          if (mid) begin
            cnt <= '0;
            sh  <= take_bit(sh, s2, fmt.msb);
            if (idx == last_idx(fmt.len7)) st <= fmt.par_en ? L_PAR : L_STOP1;
            else idx <= idx + 3'd1;
          end else if (tk) cnt <= cnt + 4'd1;
        end
        L_PAR: begin
          if (mid) begin cnt <= '0; pbit <= s2; st <= L_STOP1; end
          else if (tk) cnt <= cnt + 4'd1;
        end
        L_STOP1: begin
          if (mid) begin cnt <= '0; st <= L_IDLE; end
          else if (tk) cnt <= cnt + 4'd1;
        end
        default: st <= L_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_dbuf.sv
module uart_dbuf
  import uart_dbuf_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd,
  output logic       txd,
  output logic       irq_tx,
  output logic       irq_rx,
  output logic       irq_err
);
  localparam int FMT_W = 4 + DIV_W;

  logic [FMT_W-1:0] fmt_q;
  logic [4:0]       ctrl_q;
  logic [NFLAG-1:0] flg_q, arm_q, clr;
  logic [7:0]       tdr_q, rdr_q;

  logic tx_en, rx_en, tk, tx_load, tx_busy;
  logic rx_done, rx_perr, rx_ferr, rx_accept, ovr_now;
  logic rd_stat, wr_stat;
  logic [7:0] rx_data;
  fmt_t fmt;

  assign tx_en   = ctrl_q[0];
  assign rx_en   = ctrl_q[1];
  assign fmt     = '{len7: fmt_q[0], par_en: fmt_q[1], par_odd: fmt_q[2],
                     stop2: fmt_q[3], msb: ctrl_q[4] && !fmt_q[0]};
  assign rd_stat = bus_sel && !bus_wr && (bus_addr == A_STAT);
  assign wr_stat = bus_sel &&  bus_wr && (bus_addr == A_STAT);
  assign clr     = wr_stat ? (arm_q & ~bus_wdata[NFLAG-1:0]) : '0;
  assign tx_load = tx_en && !flg_q[F_TXE] && !tx_busy;
  assign ovr_now = rx_done && flg_q[F_RXF] && !clr[F_RXF];
  assign rx_accept = rx_done && !ovr_now;

  uart_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_in(baud_tick),
    .sel(fmt_q[FMT_W-1:4]), .tick_out(tk));

  uart_tx u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .tk(tk), .load(tx_load),
    .ld_data(tdr_q), .fmt(fmt), .txd(txd), .busy(tx_busy));

  uart_rx u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tk(tk), .rxd(rxd), .fmt(fmt),
    .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= '0; ctrl_q <= '0; tdr_q <= '0;
    end else if (bus_sel && bus_wr) begin
      if (bus_addr == A_FMT)  fmt_q  <= bus_wdata[FMT_W-1:0];
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[4:0];
      if (bus_addr == A_TXB)  tdr_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       arm_q <= '0;
    else if (rd_stat) arm_q <= flg_q;
    else if (wr_stat) arm_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= NFLAG'(1) << F_TXE;
      rdr_q <= '0;
    end else begin
      if (tx_load)          flg_q[F_TXE] <= 1'b1;
      else if (clr[F_TXE])  flg_q[F_TXE] <= 1'b0;
      if (rx_done)          flg_q[F_RXF] <= 1'b1;
      else if (clr[F_RXF])  flg_q[F_RXF] <= 1'b0;
      if (ovr_now)          flg_q[F_OVR] <= 1'b1;
      else if (clr[F_OVR])  flg_q[F_OVR] <= 1'b0;
      if (rx_done && rx_perr) flg_q[F_PAR] <= 1'b1;
      else if (clr[F_PAR])    flg_q[F_PAR] <= 1'b0;
      if (rx_done && rx_ferr) flg_q[F_FRM] <= 1'b1;
      else if (clr[F_FRM])    flg_q[F_FRM] <= 1'b0;
      if (rx_accept) rdr_q <= rx_data;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_FMT:   bus_rdata = 8'(fmt_q);
      A_CTRL:  bus_rdata = {3'b000, ctrl_q};
      A_STAT:  bus_rdata = 8'(flg_q);
      A_TXB:   bus_rdata = tdr_q;
      A_RXB:   bus_rdata = rdr_q;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq_tx  = flg_q[F_TXE] && ctrl_q[2];
  assign irq_rx  = flg_q[F_RXF] && ctrl_q[3];
  assign irq_err = (flg_q[F_OVR] || flg_q[F_PAR] || flg_q[F_FRM]) && ctrl_q[3];
endmodule

// File: rtl/uart_dbuf_chk.sv
module uart_dbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_en,
  input logic       txd,
  input logic       tx_load,
  input logic       tx_busy,
  input logic       rx_done,
  input logic [4:0] flg,
  input logic [4:0] clr,
  input logic [7:0] rdr
);
  assert_txe_after_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> flg[0]);
  assert_shifter_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tx_busy);
  assert_txd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> txd);
  assert_rxf_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> flg[1]);
  assert_overrun_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && flg[1] && !clr[1]) |=> (flg[2] && $stable(rdr)));
  assert_collision_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && clr[1]) |=> flg[1]);
  assert_rxf_no_sw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[1]) |-> $past(rx_done));
  assert_ovr_no_sw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg[2]) |-> $past(rx_done));
endmodule

bind uart_dbuf uart_dbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd), .tx_load(tx_load),
  .tx_busy(tx_busy), .rx_done(rx_done), .flg(flg_q), .clr(clr), .rdr(rdr_q));

// File: tb/sim_uart_dbuf.sv
module sim_uart_dbuf;
  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0, rxd = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic txd, irq_tx, irq_rx, irq_err;

  int checks = 0, errors = 0, idle_err = 0;
  bit finished = 0;
  int bit_clk = 16;
  bit m_len7 = 0, m_msb = 0, m_par = 0, m_odd = 0, m_stop2 = 0, mon_on = 1;
  bit tx_on = 0, hist1 = 0, hist2 = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];

  always #10 clk = ~clk;

  uart_dbuf u0 (.clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit ref_par(input logic [7:0] b, input int n, input bit odd);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += b[i];
    return bit'(ones % 2) ^ odd;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a; #1 v = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string req);
    logic [7:0] v;
    rd(a, v);
    chk(v == e, req, v, e);
  endtask

  task automatic clear_flags(input logic [7:0] mask);
    logic [7:0] v;
    rd(3'd2, v);
    wr(3'd2, ~mask);
  endtask

  task automatic tx_byte(input logic [7:0] b);
    logic [7:0] v;
    int n = 0;
    do begin rd(3'd2, v); n++; end while (!v[0] && n < 2000);
    wr(3'd3, b);
    rd(3'd2, v);
    wr(3'd2, 8'hFE);
    exp_q.push_back(m_len7 ? (b & 8'h7F) : b);
  endtask

  task automatic check_tx(input string req);
    int n = 0;
    while (got_q.size() < exp_q.size() && n < 5000) begin @(posedge clk); n++; end
    while (exp_q.size() > 0) begin
      logic [7:0] e, g;
      e = exp_q.pop_front();
      g = (got_q.size() > 0) ? got_q.pop_front() : 8'hXX;
      chk(g === e, req, g, e);
    end
    repeat (20) @(posedge clk);
  endtask

  task automatic drive_rx(input logic [7:0] b, input int nb, input bit msb,
                          input bit par_on, input bit odd, input bit bad_par,
                          input bit bad_stop);
    @(negedge clk); rxd = 0;
    repeat (bit_clk) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = msb ? b[nb-1-i] : b[i];
      repeat (bit_clk) @(negedge clk);
    end
    if (par_on) begin
      rxd = ref_par(b, nb, odd) ^ bad_par;
      repeat (bit_clk) @(negedge clk);
    end
    rxd = !bad_stop;
    repeat (bit_clk) @(negedge clk);
    rxd = 1;
    repeat (bit_clk) @(negedge clk);
  endtask

  // line monitor: decodes frames on txd with the bench's own timing
  always begin
    int bc;
    logic [7:0] v;
    @(negedge txd);
    if (mon_on) begin
      bc = bit_clk; v = '0;
      repeat (bc / 2) @(posedge clk);
      #1 chk(txd == 1'b0, "R3 start", txd, 0);
      for (int i = 0; i < (m_len7 ? 7 : 8); i++) begin
        repeat (bc) @(posedge clk);
        #1 if (m_msb && !m_len7) v = {v[6:0], txd}; else v[i] = txd;
      end
      if (m_par) begin
        repeat (bc) @(posedge clk);
        #1 chk(txd == ref_par(v, m_len7 ? 7 : 8, m_odd), "R3 parity", txd,
               ref_par(v, m_len7 ? 7 : 8, m_odd));
      end
      for (int s = 0; s < (m_stop2 ? 2 : 1); s++) begin
        repeat (bc) @(posedge clk);
        #1 chk(txd == 1'b1, "R3 stop", txd, 1);
      end
      got_q.push_back(v);
    end
  end

  // per-clock reference: a disabled transmitter keeps the line high (R10)
  always @(negedge clk) begin
    if (rst_n && !hist1 && !hist2 && txd !== 1'b1) idle_err++;
    hist2 = hist1;
    hist1 = tx_on;
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int first_late, last_kind, kind;
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    expect_reg(3'd2, 8'h01, "R1 status");
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk({irq_tx, irq_rx, irq_err} == 3'b000, "R1 irq", {irq_tx, irq_rx, irq_err}, 0);

    wr(3'd1, 8'h0F); tx_on = 1;
    chk(irq_tx == 1'b1, "R11 irq_tx", irq_tx, 1);

    // R2 handoff and buffering, R3 8N1 frames
    tx_byte(8'hA5);
    expect_reg(3'd2, 8'h01, "R2 handoff sets empty");
    tx_byte(8'h3C);
    expect_reg(3'd2, 8'h00, "R2 byte waits while shifting");
    check_tx("R2 back-to-back frames");

    // R4 MSB-first, then forced LSB-first for 7-bit frames
    wr(3'd1, 8'h1F); m_msb = 1;
    tx_byte(8'h1E);
    check_tx("R4 msb-first tx");
    wr(3'd0, 8'h01); m_len7 = 1;
    tx_byte(8'hB5);
    check_tx("R4 7-bit forced lsb tx");

    // R3 odd parity, two stops; then prescaler k=1
    wr(3'd1, 8'h0F); m_msb = 0;
    wr(3'd0, 8'h0E); m_len7 = 0; m_par = 1; m_odd = 1; m_stop2 = 1;
    tx_byte(8'h5A);
    check_tx("R3 odd parity two stops");
    wr(3'd0, 8'h10); m_par = 0; m_odd = 0; m_stop2 = 0; bit_clk = 32;
    tx_byte(8'h96);
    check_tx("R3 divided bit time");
    wr(3'd0, 8'h00); bit_clk = 16;
    repeat (40) @(posedge clk);

    // R5 receive, R11 irq
    drive_rx(8'hC3, 8, 0, 0, 0, 0, 0);
    expect_reg(3'd2, 8'h03, "R5 receive full");
    expect_reg(3'd4, 8'hC3, "R5 receive data");
    chk(irq_rx == 1'b1, "R11 irq_rx", irq_rx, 1);
    clear_flags(8'h02);
    expect_reg(3'd2, 8'h01, "R8 cleared after read");

    // R6 overrun
    drive_rx(8'h11, 8, 0, 0, 0, 0, 0);
    drive_rx(8'h22, 8, 0, 0, 0, 0, 0);
    expect_reg(3'd2, 8'h07, "R6 overrun flag");
    expect_reg(3'd4, 8'h11, "R6 old data kept");
    chk(irq_err == 1'b1, "R11 irq_err", irq_err, 1);
    clear_flags(8'h1E);
    expect_reg(3'd2, 8'h01, "R8 clear all rx flags");
    wr(3'd2, 8'h01);  // drop the arm left by the read above

    // R8 clear protocol
    drive_rx(8'h33, 8, 0, 0, 0, 0, 0);
    wr(3'd2, 8'h01);
    expect_reg(3'd2, 8'h03, "R8 write 0 without read");
    wr(3'd2, 8'hFF);
    expect_reg(3'd2, 8'h03, "R8 write 1 no effect");
    wr(3'd2, 8'hFD);
    expect_reg(3'd2, 8'h01, "R8 read then write 0");

    // R9 read-only receive register
    wr(3'd4, 8'h77);
    expect_reg(3'd4, 8'h33, "R9 receive reg read-only");

    // R7 parity and framing errors
    wr(3'd0, 8'h02);
    drive_rx(8'h6D, 8, 0, 1, 0, 1, 0);
    expect_reg(3'd2, 8'h0B, "R7 parity error");
    clear_flags(8'h1E);
    drive_rx(8'h6D, 8, 0, 1, 0, 0, 0);
    expect_reg(3'd2, 8'h03, "R7 good parity");
    clear_flags(8'h1E);
    wr(3'd0, 8'h00);
    drive_rx(8'h44, 8, 0, 0, 0, 0, 1);
    expect_reg(3'd2, 8'h13, "R7 framing error");
    clear_flags(8'h1E);

    // R4 receive 7-bit with msb bit set -> lsb-first
    wr(3'd0, 8'h01); wr(3'd1, 8'h1F);
    drive_rx(8'h4B, 7, 0, 0, 0, 0, 0);
    expect_reg(3'd4, 8'h4B, "R4 7-bit rx lsb-first");
    clear_flags(8'h1E);
    wr(3'd0, 8'h00);

    // R10 receiver disabled
    wr(3'd1, 8'h0D);
    drive_rx(8'h99, 8, 0, 0, 0, 0, 0);
    expect_reg(3'd2, 8'h01, "R10 rx disabled status");
    expect_reg(3'd4, 8'h4B, "R10 rx disabled data");

    // R10 transmitter disabled mid-frame
    mon_on = 0;
    wr(3'd3, 8'hF0); rd(3'd2, v); wr(3'd2, 8'hFE);
    repeat (40) @(posedge clk);
    wr(3'd1, 8'h0E); tx_on = 0;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1, "R10 txd high when disabled", txd, 1);
    repeat (100) @(negedge clk);

    // R12 collision sweep: clear of receive-full vs frame completion
    wr(3'd1, 8'h0A);
    clear_flags(8'h1E);
    first_late = -1; last_kind = 0;
    for (int off = 140; off <= 170; off++) begin
      logic [7:0] st, dd;
      drive_rx(8'h5C, 8, 0, 0, 0, 0, 0);
      rd(3'd2, v);
      fork
        drive_rx(8'hE1, 8, 0, 0, 0, 0, 0);
        begin repeat (off) @(posedge clk); wr(3'd2, 8'hFD); end
      join
      repeat (10) @(posedge clk);
      rd(3'd2, st); rd(3'd4, dd);
      if (st[2:1] == 2'b01 && dd == 8'hE1) kind = 1;
      else if (st[2:1] == 2'b10 && dd == 8'h5C) kind = 2;
      else kind = 3;
      chk(kind != 3, "R12 consistent outcome", {st, dd}, off);
      chk(!(last_kind == 2 && kind == 1), "R12 single crossover", kind, 2);
      if (kind == 2 && first_late < 0) first_late = off;
      if (off == 140) chk(kind == 1, "R12 early clear keeps new byte", kind, 1);
      if (off == 170) chk(kind == 2, "R12 late clear overruns", kind, 2);
      last_kind = kind;
      clear_flags(8'h1E);
    end

    chk(idle_err == 0, "R10 per-clock idle line", idle_err, 0);
    finish_run();
  end
endmodule